// File: doc/BRIEF.md
# Transposed FIR Filter with Shift-Add Constant Multiplier Block

This block is an 18-tap FIR filter built in transposed form. Each clock it takes one signed 8-bit sample and returns a signed 33-bit filtered value from an output register. The coefficients are fixed before synthesis and are passed in as one packed parameter.

The current sample is scaled by all eighteen coefficients at once in a single product network. No general multiplier is used. Each coefficient is recoded at elaboration into canonical signed digits. Each nonzero digit then selects one pre-shifted copy of the sample, which is added or subtracted. All taps share the same set of shifted copies.

Each product enters an adder. The adder's other operand is the registered partial sum of the next-higher tap. Seventeen delay registers link the eighteen adders, and the lowest partial sum is the output register. A synchronous reset zeroes every partial sum.

Top module: `fir_transposed_mcm`

## Requirements
- R1: At a clock edge where `rst` is high, every partial sum and `filtOut` become zero whatever `sampleIn` is. `filtOut` reads zero while reset is held.
- R2: A sample applied at clock edge n adds h0·x to `filtOut` right after that same edge (one register of latency).
- R3: A single sample of value v, followed by zeros, produces h0·v, h1·v, …, h17·v on 18 consecutive cycles. `filtOut` is zero from then on while the input stays zero.
- R4: After edge n, `filtOut` equals the sum over k = 0..17 of h_k · x[n−k], in two's-complement signed arithmetic. Samples from before the last reset count as zero.
- R5: Results are exact for extreme operands, including the product −128 × −128 = 16384 and long runs of 127 or −128, with no wrap in the 33-bit output.
- R6: A reset applied in the middle of a stream discards all earlier samples. An impulse applied after the release gives exactly the coefficient sequence.
- R7: Coefficient h_k is the signed 8-bit field `COEFS[8k+7:8k]`. h0 sits in the least significant byte and is the first value of the impulse response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears every partial sum |
| sampleIn | input | 8 | Signed two's-complement input sample, one per clock |
| filtOut | output | 33 | Signed registered filter output |

## Verification
The bench first targets the extreme operands: −128 in front of the −128 coefficient, and long runs of 127 and −128. A product network that drops the sign or uses a too-narrow product would return a positive-wrapped or truncated value there.

Single impulses of +1, −1, −128 and 127 check that the coefficients come out in order and that the tail returns to zero. A reversed chain or a mis-packed coefficient field would show the sequence backwards or shifted.

A reset applied in the middle of a random stream, with a large sample on the input at the same time, catches registers that are missed by the clear or that still load on the reset edge.

Long random streams are compared sample by sample against a direct-form convolution model.

// File: rtl/fir_mcm_pkg.sv
`timescale 1ns/1ps
package fir_mcm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero all partial sums this edge
    logic advance;  // load the next partial sums this edge
  } fir_ctrl_t;

  // Canonical signed-digit recoding of a constant.
  // Returns the mask of +1 digits (wantNeg = 0) or of -1 digits (wantNeg = 1).
  function automatic logic [31:0] csdMask(input int value, input bit wantNeg);
    int          rem;
    logic [31:0] mask;
    mask = '0;
    rem  = value;
    for (int i = 0; i < 31; i++) begin
      if (rem[0]) begin
        if (rem[1]) begin
          if (wantNeg) mask[i] = 1'b1;
          rem = rem + 1;
        end else begin
          if (!wantNeg) mask[i] = 1'b1;
          rem = rem - 1;
        end
      end
      rem = rem >>> 1;
    end
    return mask;
  endfunction

endpackage

// File: rtl/fir_mcm_ctrl.sv
`timescale 1ns/1ps
module fir_mcm_ctrl
  import fir_mcm_pkg::*;
(
  input  logic      rst,
  output fir_ctrl_t ctrl
);

  always_comb begin
    ctrl.clear   = rst;
    ctrl.advance = !rst;
  end

endmodule

// File: rtl/fir_mcm_products.sv
`timescale 1ns/1ps
module fir_mcm_products
  import fir_mcm_pkg::*;
#(
  parameter int NUM_TAPS = 18,
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int PROD_W   = DATA_W + COEF_W,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic signed [DATA_W-1:0]            sampleIn,
  output logic        [NUM_TAPS-1:0][PROD_W-1:0] products
);

  localparam int DIGITS = COEF_W + 1;

  // One set of shifted copies of the sample, shared by every tap
  logic signed [PROD_W-1:0] shifted [DIGITS];

  for (genvar k = 0; k < DIGITS; k++) begin : g_shift
    assign shifted[k] = PROD_W'(sampleIn) <<< k;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int          COEF_VAL = int'($signed(COEFS[t*COEF_W +: COEF_W]));
    localparam logic [31:0] POS_MASK = csdMask(COEF_VAL, 1'b0);
    localparam logic [31:0] NEG_MASK = csdMask(COEF_VAL, 1'b1);

    logic signed [PROD_W-1:0] acc;

    // Modular sum; the final value always fits PROD_W bits
    always_comb begin
      acc = '0;
      for (int k = 0; k < DIGITS; k++) begin
        if (POS_MASK[k]) acc = acc + shifted[k];
        if (NEG_MASK[k]) acc = acc - shifted[k];
      end
    end

    assign products[t] = acc;
  end

endmodule

// File: rtl/fir_mcm_chain.sv
`timescale 1ns/1ps
module fir_mcm_chain
  import fir_mcm_pkg::*;
#(
  parameter int NUM_TAPS = 18,
  parameter int PROD_W   = 16,
  parameter int OUT_W    = 33
) (
  input  logic                               clk,
  input  fir_ctrl_t                          ctrl,
  input  logic [NUM_TAPS-1:0][PROD_W-1:0]    products,
  output logic signed [OUT_W-1:0]            sumOut
);

  // partial[0] is the output register; partial[1..NUM_TAPS-1] are the delays
  logic signed [OUT_W-1:0] partial     [NUM_TAPS];
  logic signed [OUT_W-1:0] nextPartial [NUM_TAPS];

  always_comb begin
    nextPartial[NUM_TAPS-1] = OUT_W'($signed(products[NUM_TAPS-1]));
    for (int t = 0; t < NUM_TAPS - 1; t++) begin
      nextPartial[t] = OUT_W'($signed(products[t])) + partial[t+1];
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      for (int t = 0; t < NUM_TAPS; t++) partial[t] <= '0;
    end else if (ctrl.advance) begin
      partial <= nextPartial;
    end
  end

  assign sumOut = partial[0];

endmodule

// File: rtl/fir_mcm_datapath.sv
`timescale 1ns/1ps
module fir_mcm_datapath
  import fir_mcm_pkg::*;
#(
  parameter int NUM_TAPS = 18,
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 33,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  fir_ctrl_t                ctrl,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [OUT_W-1:0]  filtOut
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic [NUM_TAPS-1:0][PROD_W-1:0] tapProducts;

  fir_mcm_products #(
    .NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .PROD_W(PROD_W), .COEFS(COEFS)
  ) products_i (
    .sampleIn(sampleIn),
    .products(tapProducts)
  );

  fir_mcm_chain #(
    .NUM_TAPS(NUM_TAPS), .PROD_W(PROD_W), .OUT_W(OUT_W)
  ) chain_i (
    .clk     (clk),
    .ctrl    (ctrl),
    .products(tapProducts),
    .sumOut  (filtOut)
  );

endmodule

// File: rtl/fir_transposed_mcm.sv
`timescale 1ns/1ps
module fir_transposed_mcm
  import fir_mcm_pkg::*;
#(
  parameter int NUM_TAPS = 18,
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 33,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    144'h05_F9_01_0C_E7_28_C0_60_80_7F_60_C0_28_E7_0C_00_F9_03
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [OUT_W-1:0]  filtOut
);

  fir_ctrl_t ctrlStrobes;

  fir_mcm_ctrl ctrl_i (
    .rst (rst),
    .ctrl(ctrlStrobes)
  );

  fir_mcm_datapath #(
    .NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .OUT_W(OUT_W), .COEFS(COEFS)
  ) datapath_i (
    .clk     (clk),
    .ctrl    (ctrlStrobes),
    .sampleIn(sampleIn),
    .filtOut (filtOut)
  );

endmodule

// File: rtl/fir_mcm_checker.sv
`timescale 1ns/1ps
module fir_mcm_checker #(
  parameter int NUM_TAPS = 18,
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int OUT_W    = 33,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [DATA_W-1:0] sampleIn,
  input logic signed [OUT_W-1:0]  filtOut
);

  localparam int RUN_W = $clog2(NUM_TAPS) + 2;

  function automatic longint magBound();
    longint s;
    s = 0;
    for (int t = 0; t < NUM_TAPS; t++) begin
      longint c;
      c = longint'($signed(COEFS[t*COEF_W +: COEF_W]));
      s += (c < 0 ? -c : c);
    end
    return s * (longint'(1) <<< (DATA_W - 1));
  endfunction

  localparam logic signed [OUT_W-1:0] BOUND = OUT_W'(magBound());

  // Direct-form reference model
  logic signed [DATA_W-1:0] past [NUM_TAPS];
  logic signed [OUT_W-1:0]  modelNext, modelOut;
  logic                     armed;
  logic [RUN_W-1:0]         zeroRun;

  always_comb begin
    modelNext = OUT_W'($signed(COEFS[0 +: COEF_W])) * OUT_W'(sampleIn);
    for (int t = 1; t < NUM_TAPS; t++) begin
      modelNext = modelNext
                + OUT_W'($signed(COEFS[t*COEF_W +: COEF_W])) * OUT_W'(past[t-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TAPS; t++) past[t] <= '0;
      modelOut <= '0;
      armed    <= 1'b1;
      zeroRun  <= '0;
    end else begin
      past[0] <= sampleIn;
      for (int t = 1; t < NUM_TAPS; t++) past[t] <= past[t-1];
      modelOut <= modelNext;
      if (sampleIn != '0) zeroRun <= '0;
      else if (zeroRun < RUN_W'(NUM_TAPS)) zeroRun <= zeroRun + 1'b1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> filtOut == '0);

  p_tail_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (zeroRun >= RUN_W'(NUM_TAPS - 1) && sampleIn == '0) |=> filtOut == '0);

  p_conv_match_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> filtOut == modelOut);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (filtOut <= BOUND && filtOut >= -BOUND));

endmodule

bind fir_transposed_mcm fir_mcm_checker #(
  .NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
  .OUT_W(OUT_W), .COEFS(COEFS)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .sampleIn(sampleIn),
  .filtOut (filtOut)
);

// File: tb/fir_transposed_mcm_tb_top.sv
`timescale 1ns/1ps
module fir_transposed_mcm_tb_top;

  localparam int NT = 18;

  // Bench's own coefficient list, h0 first
  int coefList [NT] = '{3, -7, 0, 12, -25, 40, -64, 96, 127, -128,
                        96, -64, 40, -25, 12, 1, -7, 5};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [7:0]  sampleIn = '0;
  logic signed [32:0] filtOut;

  int checks   = 0;
  int failures = 0;

  longint expQ [$];
  string  tagQ [$];
  int     hist [NT];

  always #10 clk = ~clk;

  fir_transposed_mcm #(
    .NUM_TAPS(18), .DATA_W(8), .COEF_W(8), .OUT_W(33),
    .COEFS(144'h05_F9_01_0C_E7_28_C0_60_80_7F_60_C0_28_E7_0C_00_F9_03)
  ) dut_i (
    .clk     (clk),
    .rst     (rst),
    .sampleIn(sampleIn),
    .filtOut (filtOut)
  );

  // Driver: applies one sample per clock and queues the expected output
  task automatic step(input int x, input bit r, input string tag);
    longint e;
    @(negedge clk);
    rst      = r;
    sampleIn = 8'(x);
    if (r) begin
      for (int i = 0; i < NT; i++) hist[i] = 0;
      e = 0;
    end else begin
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      e = 0;
      for (int i = 0; i < NT; i++) e += longint'(coefList[i]) * longint'(hist[i]);
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 1'b0, tag);
  endtask

  // Monitor: compares results a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      longint e;
      string  tg;
      e  = expQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if (longint'(filtOut) !== e) begin
        failures++;
        $display("FAIL %s: filtOut=%0d expected=%0d at %0t", tg, longint'(filtOut), e, $time);
      end
    end
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;

    // R1: reset state with a nonzero sample held on the input
    for (int i = 0; i < 4; i++) step(100, 1'b1, "R1");

    // R2 latency, R3 impulse tail, R7 coefficient order
    step(1, 1'b0, "R2");
    zeros(NT - 1, "R7");
    zeros(4, "R3");

    step(-1, 1'b0, "R3");
    zeros(NT + 2, "R3");

    // R5: extreme impulses, including -128 * -128
    step(-128, 1'b0, "R5");
    zeros(NT + 2, "R5");
    step(127, 1'b0, "R5");
    zeros(NT + 2, "R5");

    // R5: long saturating runs and alternation
    for (int i = 0; i < 30; i++) step(127, 1'b0, "R5");
    for (int i = 0; i < 30; i++) step(-128, 1'b0, "R5");
    for (int i = 0; i < 40; i++) step((i % 2) ? 127 : -128, 1'b0, "R5");
    zeros(NT, "R3");

    // R4: random stream
    for (int i = 0; i < 400; i++) step(int'($urandom_range(0, 255)) - 128, 1'b0, "R4");

    // R5: random extreme values
    for (int i = 0; i < 200; i++) begin
      int pick;
      int v;
      pick = int'($urandom_range(0, 4));
      v = (pick == 0) ? -128 : (pick == 1) ? 127 : (pick == 2) ? -1 : (pick == 3) ? 1 : 0;
      step(v, 1'b0, "R5");
    end

    // R6: mid-stream reset, then a clean impulse
    for (int i = 0; i < 10; i++) step(int'($urandom_range(0, 255)) - 128, 1'b0, "R4");
    step(-128, 1'b1, "R1");
    step(1, 1'b0, "R6");
    zeros(NT + 2, "R6");

    @(posedge clk);
    #8;
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R4: pending results=%0d expected=0", expQ.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule